// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the 32 input pins of one general-purpose I/O port and raises a single interrupt line for the whole port. Each pin has a 2-bit trigger code that selects one of four conditions: a rising edge, a falling edge, a high level or a low level. When the selected condition is seen on a pin, the pin's bit in an event status register is set. Software clears a status bit by writing a one to it.

A per-pin mask controls which latched events drive the port interrupt. A pin only takes part when it is selected for GPIO use and configured as an input. Pin inputs are asynchronous, so they pass through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier.

Registers are reached through a simple 32-bit bus. A write takes effect on the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. The word addresses are:

| Address | Register | Reset value |
|---|---|---|
| 0 | trigger codes for pins 0 to 15 | 0 |
| 1 | trigger codes for pins 16 to 31 | 0 |
| 2 | GPIO-use select | 0 |
| 3 | direction (1 = output) | 0 |
| 4 | interrupt mask | 0 |
| 5 | event status (write one to clear) | 0 |

Top module: `gpio_irq_port`

## Requirements
- R1: With trigger code 2'b00, a 0-to-1 change on the synchronized pin sets the pin's status bit. A 1-to-0 change does not set it.
- R2: With trigger code 2'b01, a 1-to-0 change sets the pin's status bit. A 0-to-1 change does not set it.
- R3: With trigger code 2'b10, the status bit is set on every cycle the pin is high. While the level holds, a write-one clear leaves the bit set. Once the pin is low, the clear works.
- R4: With trigger code 2'b11, the status bit is set on every cycle the pin is low. A pin that stays high does not set it.
- R5: The trigger code of pin p sits at bits [2*(p mod 16)+1 : 2*(p mod 16)]. Pins 0 to 15 use the register at address 0 and pins 16 to 31 use the register at address 1. Both registers read back what was written.
- R6: Writing the status register (address 5) clears every bit written as 1. Bits written as 0 keep their value.
- R7: If a pin's event and a write-one clear of the same bit fall in the same cycle, the bit stays set.
- R8: `port_irq` is high exactly when some status bit is set and the mask bit (address 4) of the same pin is 1.
- R9: A pin sets its status bit only when its GPIO-use bit (address 2) is 1 and its direction bit (address 3) is 0. Any other pin never sets its status bit.
- R10: After reset, all six registers read 0 and `port_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Asynchronous pin levels |
| port_irq | output | 1 | Combined port interrupt |

## Verification
The embedded assertions check, on every clock, that:
- a write-one clear removes exactly the bits whose event is absent,
- zero bits of a status write leave state alone,
- a coinciding event keeps its bit set,
- a newly set status bit always belongs to an enabled input pin,
- the interrupt never rises with an empty mask or an empty status.

Only the bench scenarios can show that each trigger code picks the right condition, and that codes land in the right field and register half. They also show that a held level re-arms its bit against a clear, and that an event reaches status after the synchronizer delay.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int PIN_COUNT      = 32;
    localparam int CODE_W         = 2;
    localparam int PINS_PER_HALF  = 16;
    localparam int ADDR_W         = 3;

    typedef enum logic [CODE_W-1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_LOW  = 2'b11
    } trig_code_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_TRIG_LO = 3'd0,
        REG_TRIG_HI = 3'd1,
        REG_USE     = 3'd2,
        REG_DIR     = 3'd3,
        REG_MASK    = 3'd4,
        REG_STATUS  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] prev_out
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
    assign prev_out = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic [PIN_COUNT-1:0]                 cur_lvl,
    input  logic [PIN_COUNT-1:0]                 old_lvl,
    input  logic [PINS_PER_HALF*CODE_W-1:0]      trig_lo,
    input  logic [PINS_PER_HALF*CODE_W-1:0]      trig_hi,
    input  logic [PIN_COUNT-1:0]                 use_sel,
    input  logic [PIN_COUNT-1:0]                 dir_out,
    output logic [PIN_COUNT-1:0]                 evt
);
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        localparam int FIELD = CODE_W * (p % PINS_PER_HALF);
        trig_code_e code;
        logic       hit;

        if (p < PINS_PER_HALF) begin : g_lo
            assign code = trig_code_e'(trig_lo[FIELD +: CODE_W]);
        end else begin : g_hi
            assign code = trig_code_e'(trig_hi[FIELD +: CODE_W]);
        end

        always_comb begin
            unique case (code)
                TRIG_RISE: hit =  cur_lvl[p] & ~old_lvl[p];
                TRIG_FALL: hit = ~cur_lvl[p] &  old_lvl[p];
                TRIG_HIGH: hit =  cur_lvl[p];
                TRIG_LOW:  hit = ~cur_lvl[p];
                default:   hit = 1'b0;
            endcase
        end

        assign evt[p] = hit & use_sel[p] & ~dir_out[p];
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    input  logic [PIN_COUNT-1:0]            evt,
    output logic [PINS_PER_HALF*CODE_W-1:0] trig_lo,
    output logic [PINS_PER_HALF*CODE_W-1:0] trig_hi,
    output logic [PIN_COUNT-1:0]            use_sel,
    output logic [PIN_COUNT-1:0]            dir_out,
    output logic [PIN_COUNT-1:0]            mask,
    output logic [PIN_COUNT-1:0]            status
);
    logic                 wr_status;
    logic [PIN_COUNT-1:0] clr_bits;

    assign wr_status = bus_wr && (reg_addr_e'(bus_addr) == REG_STATUS);
    assign clr_bits  = wr_status ? bus_wdata[PIN_COUNT-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_lo <= '0;
            trig_hi <= '0;
            use_sel <= '0;
            dir_out <= '0;
            mask    <= '0;
            status  <= '0;
        end else begin
            if (bus_wr) begin
                unique case (reg_addr_e'(bus_addr))
                    REG_TRIG_LO: trig_lo <= bus_wdata;
                    REG_TRIG_HI: trig_hi <= bus_wdata;
                    REG_USE:     use_sel <= bus_wdata[PIN_COUNT-1:0];
                    REG_DIR:     dir_out <= bus_wdata[PIN_COUNT-1:0];
                    REG_MASK:    mask    <= bus_wdata[PIN_COUNT-1:0];
                    default:     ;
                endcase
            end
            status <= (status & ~clr_bits) | evt;
        end
    end

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            REG_TRIG_LO: bus_rdata = trig_lo;
            REG_TRIG_HI: bus_rdata = trig_hi;
            REG_USE:     bus_rdata = use_sel;
            REG_DIR:     bus_rdata = dir_out;
            REG_MASK:    bus_rdata = mask;
            REG_STATUS:  bus_rdata = status;
            default:     bus_rdata = '0;
        endcase
    end

    // R6: bits written as one without a coinciding event are gone next cycle
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((status & $past(bus_wdata[PIN_COUNT-1:0]) & ~$past(evt)) == '0));

    // R6: bits written as zero keep a set value
    assert_zero_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((($past(status) & ~$past(bus_wdata[PIN_COUNT-1:0])) & ~status) == '0));

    // R7: an event always leaves its bit set, whatever the bus wrote
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));

    // R9: a freshly set status bit belongs to an enabled input pin
    assert_only_enabled_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status & ~$past(status)) & ~($past(use_sel) & ~$past(dir_out))) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic        port_irq
);
    logic [PIN_COUNT-1:0]            cur_lvl, old_lvl, evt;
    logic [PINS_PER_HALF*CODE_W-1:0] trig_lo, trig_hi;
    logic [PIN_COUNT-1:0]            use_sel, dir_out, mask, status;

    gpio_irq_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (cur_lvl),
        .prev_out (old_lvl)
    );

    gpio_irq_detect u_detect (
        .cur_lvl (cur_lvl),
        .old_lvl (old_lvl),
        .trig_lo (trig_lo),
        .trig_hi (trig_hi),
        .use_sel (use_sel),
        .dir_out (dir_out),
        .evt     (evt)
    );

    gpio_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt),
        .trig_lo   (trig_lo),
        .trig_hi   (trig_hi),
        .use_sel   (use_sel),
        .dir_out   (dir_out),
        .mask      (mask),
        .status    (status)
    );

    assign port_irq = |(status & mask);

    // R8: no interrupt while every mask bit is clear
    assert_mask_gates_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !port_irq);

    // R8: no interrupt without a latched event
    assert_irq_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !port_irq);
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic        port_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] sh_lo = '0;
    logic [31:0] sh_hi = '0;

    always #5 clk = ~clk;

    gpio_irq_port i_gpio_irq_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .port_irq  (port_irq)
    );

    typedef struct packed {
        logic [4:0] pin;
        logic [1:0] code;
        logic       lvl_from;
        logic       lvl_to;
        logic       expect_set;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{pin: 5'd0,  code: 2'b00, lvl_from: 1'b0, lvl_to: 1'b1, expect_set: 1'b1}, // R1 rising seen
        '{pin: 5'd1,  code: 2'b00, lvl_from: 1'b1, lvl_to: 1'b0, expect_set: 1'b0}, // R1 falling ignored
        '{pin: 5'd17, code: 2'b01, lvl_from: 1'b1, lvl_to: 1'b0, expect_set: 1'b1}, // R2 falling seen, R5 high half
        '{pin: 5'd18, code: 2'b01, lvl_from: 1'b0, lvl_to: 1'b1, expect_set: 1'b0}, // R2 rising ignored
        '{pin: 5'd5,  code: 2'b10, lvl_from: 1'b0, lvl_to: 1'b1, expect_set: 1'b1}, // R3 high level
        '{pin: 5'd20, code: 2'b10, lvl_from: 1'b0, lvl_to: 1'b0, expect_set: 1'b0}, // R3 stays low
        '{pin: 5'd9,  code: 2'b11, lvl_from: 1'b1, lvl_to: 1'b0, expect_set: 1'b1}, // R4 low level
        '{pin: 5'd31, code: 2'b11, lvl_from: 1'b1, lvl_to: 1'b1, expect_set: 1'b0}  // R4 stays high
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_code(input int p, input logic [1:0] c);
        int f;
        f = 2 * (p % 16);
        if (p < 16) begin
            sh_lo[f +: 2] = c;
            bus_write(3'd0, sh_lo);
        end else begin
            sh_hi[f +: 2] = c;
            bus_write(3'd1, sh_hi);
        end
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state of every register and the output
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), rd);
            check("R10 register reset", rd, 32'h0);
        end
        check("R10 irq low after reset", {31'b0, port_irq}, 32'h0);

        // enable all pins as inputs, unmask all
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_write(3'd3, 32'h0);
        bus_write(3'd4, 32'hFFFF_FFFF);

        for (int v = 0; v < NVEC; v++) begin
            vec_t t;
            t = VECS[v];
            set_code(int'(t.pin), t.code);
            pin_in[t.pin] = t.lvl_from;
            idle(4);
            bus_write(3'd5, 32'hFFFF_FFFF);
            idle(1);
            pin_in[t.pin] = t.lvl_to;
            idle(4);
            bus_read(3'd5, rd);
            check("R1/R2/R3/R4 status after trigger", rd, {31'b0, t.expect_set} << t.pin);
            check("R8 irq follows status", {31'b0, port_irq}, {31'b0, t.expect_set});
            bus_read(t.pin < 16 ? 3'd0 : 3'd1, rd);
            check("R5 trigger field readback", {30'b0, rd[2*(t.pin % 16) +: 2]}, {30'b0, t.code});
            set_code(int'(t.pin), 2'b00);
            pin_in[t.pin] = 1'b0;
            idle(4);
            bus_write(3'd5, 32'hFFFF_FFFF);
        end

        // R6 write-one clears only selected bits; zero write keeps state
        pin_in[1:0] = 2'b11;
        idle(4);
        bus_write(3'd5, 32'h0000_0000);
        bus_read(3'd5, rd);
        check("R6 zero write keeps bits", rd, 32'h3);
        bus_write(3'd5, 32'h0000_0001);
        bus_read(3'd5, rd);
        check("R6 one write clears bit0 only", rd, 32'h2);
        pin_in[1:0] = 2'b00;
        bus_write(3'd5, 32'hFFFF_FFFF);

        // R3 / R7 held high level beats the clear
        set_code(5, 2'b10);
        pin_in[5] = 1'b1;
        idle(4);
        bus_write(3'd5, 32'h0000_0020);
        bus_read(3'd5, rd);
        check("R7 event wins over clear while level holds", rd, 32'h20);
        pin_in[5] = 1'b0;
        idle(4);
        bus_write(3'd5, 32'h0000_0020);
        bus_read(3'd5, rd);
        check("R3 clear works after level drops", rd, 32'h0);
        set_code(5, 2'b00);

        // R8 mask gating
        bus_write(3'd4, 32'h0);
        pin_in[0] = 1'b1;
        idle(4);
        check("R8 masked event gives no irq", {31'b0, port_irq}, 32'h0);
        bus_write(3'd4, 32'hFFFF_FFFE);
        check("R8 other mask bits give no irq", {31'b0, port_irq}, 32'h0);
        bus_write(3'd4, 32'h0000_0001);
        #1 check("R8 unmasked event raises irq", {31'b0, port_irq}, 32'h1);
        pin_in[0] = 1'b0;
        bus_write(3'd5, 32'hFFFF_FFFF);
        #1 check("R8 irq drops after clear", {31'b0, port_irq}, 32'h0);

        // R9 pins not in GPIO use, or set as outputs, never set status
        bus_write(3'd2, 32'hFFFF_FFFB);
        bus_write(3'd3, 32'h0000_0008);
        pin_in[3:2] = 2'b11;
        idle(4);
        bus_read(3'd5, rd);
        check("R9 disabled pins set nothing", rd, 32'h0);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_write(3'd3, 32'h0);
        idle(2);
        bus_read(3'd5, rd);
        check("R9 nothing latched after re-enable", rd, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule